// File: doc/BRIEF.md
# Serial Transmit Framer with Clear-to-Send Gating

This block turns bytes offered on a valid/ready interface into an asynchronous serial bit stream on a single output line. An external enable pulse, called the oversampling tick, runs at sixteen times the bit rate. Every bit on the line lasts a fixed number of those ticks. Each character is sent as a low start bit, then the data bits least significant first, then an optional parity bit (even or odd), then a high stop bit. When there is nothing to send, the line rests high.

When flow control is switched on, an active-low clear-to-send input decides whether the next character may begin. That input is looked at only at a character boundary, and it is passed through a small synchronizer first. Once a character has started, the input has no effect on it. A direct override lets software place a fixed level on the line. The serializer keeps running underneath the override, so its bit timing is not disturbed. The producer side holds bytes in a queue outside this block. The queue also supplies the tick.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, and whenever no character is in flight and the override is off, `txd_o` is 1 and `busy_o` is 0.
- R2: A character is sent as a start bit of 0, then `tx_data_i` bit 0 through bit 7, then a stop bit of 1. Each bit lasts exactly 16 oversampling ticks. The start bit begins on the clock edge that accepts the byte.
- R3: With `par_en_i`=1, one parity bit goes between data bit 7 and the stop bit. It equals the XOR of the eight data bits when `par_odd_i`=0, and the inverse of that XOR when `par_odd_i`=1.
- R4: With `par_en_i`=0, the stop bit directly follows data bit 7, so the frame is 10 bits long.
- R5: `tx_ready_o` is high only in a cycle in which `tick_i` is high, the serializer is idle or in the last tick of its stop bit, and the clear-to-send condition allows a start. A byte is taken on a clock edge where both `tx_valid_i` and `tx_ready_o` are high.
- R6: If a byte is offered during the last tick of a stop bit, the next start bit follows at once, with no idle time between frames.
- R7: With `flow_en_i`=1 and `cts_ni`=1, no character starts. After `cts_ni` falls, a start becomes possible once the synchronizer has passed the new level (2 clock cycles by default).
- R8: A change on `cts_ni` while a character is in flight does not alter that character's bits or timing.
- R9: With `flow_en_i`=0, the value of `cts_ni` has no effect on when characters start.
- R10: While `ovr_en_i`=1, `txd_o` equals `ovr_val_i`. The frame in flight keeps its timing, so after the override is released the remaining bits appear on schedule.
- R11: A bit lasts 16 ticks however many clock cycles separate consecutive ticks.
- R12: The parity enable and parity sense are captured when a byte is accepted. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, sixteen per bit |
| tx_valid_i | input | 1 | A byte is offered |
| tx_data_i | input | DATA_W | Offered byte |
| tx_ready_o | output | 1 | Byte is taken this cycle if valid |
| par_en_i | input | 1 | Insert a parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| flow_en_i | input | 1 | Gate character starts on clear-to-send |
| cts_ni | input | 1 | Clear-to-send, active low |
| ovr_en_i | input | 1 | Drive the line from `ovr_val_i` |
| ovr_val_i | input | 1 | Level forced onto the line |
| txd_o | output | 1 | Serial output line |
| busy_o | output | 1 | A character is in flight |

## Verification
Some properties are checked on every cycle. The line holds still within a bit, and the tick counter stays in range and moves only on ticks. The handshake appears only on a tick, outside the body of a frame, and only when clear-to-send permits. An offer at the end of a stop bit always produces an immediate start bit, and the idle line is high.

Other behaviour can only be shown by the bench's scenarios. These cover the actual bit values of every byte with no parity and with even parity, and of a spread of bytes with odd parity. They also cover stretched tick spacing, format changes made mid-frame, an override held across part of a frame, and clear-to-send held off, released, and toggled mid-character.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_START  = 3'd1,
      PH_DATA   = 3'd2,
      PH_PARITY = 3'd3,
      PH_STOP   = 3'd4
   } phase_e;

   typedef struct packed {
      logic par_en;
      logic par_odd;
   } fmt_t;

endpackage

// File: rtl/ser_tx_cts_sync.sv
module ser_tx_cts_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);

   initial begin
      a_stages_ok: assert (STAGES <= 8)
         else $error("ser_tx_cts_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_o = async_i;
      end else begin : g_chain
         // Reset to 1 so flow control reads as "not clear" until sampled.
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               chain_q <= '1;
            end else if (STAGES == 1) begin
               chain_q[0] <= async_i;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], async_i};
            end
         end
         assign sync_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ser_tx_bit_timer.sv
module ser_tx_bit_timer #(
   parameter int unsigned OSR = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic run_i,
   input  logic restart_i,
   output logic bit_end_o
);

   localparam int unsigned CNT_W = (OSR > 2) ? $clog2(OSR) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

   initial begin
      a_osr_ok: assert (OSR >= 2)
         else $error("ser_tx_bit_timer: OSR must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (run_i && tick_i) begin
         cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   assign bit_end_o = run_i && tick_i && (cnt_q == CNT_LAST);

   a_r11_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_LAST);

   a_r11_cnt_waits_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ser_tx_parity.sv
module ser_tx_parity #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              odd_i,
   output logic              par_o
);

   logic [DATA_W:0] chain;

   assign chain[0] = odd_i;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_fold
         assign chain[i+1] = chain[i] ^ data_i[i];
      end
   endgenerate

   assign par_o = chain[DATA_W];

endmodule

// File: rtl/ser_tx_frame_fsm.sv
module ser_tx_frame_fsm
   import ser_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              bit_end_i,
   input  logic              cts_ok_i,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              par_bit_i,
   input  fmt_t              fmt_i,
   output logic              ready_o,
   output logic              launch_o,
   output logic              busy_o,
   output logic              line_o
);

   localparam int unsigned IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   initial begin
      a_width_ok: assert (DATA_W >= 5 && DATA_W <= 9)
         else $error("ser_tx_frame_fsm: DATA_W out of range");
   end

   phase_e            phase_q;
   logic [DATA_W-1:0] shreg_q;
   logic [IDX_W-1:0]  idx_q;
   logic              par_q;
   logic              pen_q;
   logic              at_boundary;

   // A new character may begin from idle, or on the closing tick of a stop bit.
   assign at_boundary = (phase_q == PH_IDLE) || (phase_q == PH_STOP && bit_end_i);
   assign ready_o     = tick_i && cts_ok_i && at_boundary;
   assign launch_o    = ready_o && valid_i;
   assign busy_o      = (phase_q != PH_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         shreg_q <= '0;
         idx_q   <= '0;
         par_q   <= 1'b0;
         pen_q   <= 1'b0;
      end else if (launch_o) begin
         phase_q <= PH_START;
         shreg_q <= data_i;
         idx_q   <= '0;
         par_q   <= par_bit_i;
         pen_q   <= fmt_i.par_en;
      end else if (bit_end_i) begin
         case (phase_q)
            PH_START: phase_q <= PH_DATA;
            PH_DATA: begin
               shreg_q <= shreg_q >> 1;
               if (idx_q == IDX_LAST) begin
                  phase_q <= pen_q ? PH_PARITY : PH_STOP;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PH_PARITY: phase_q <= PH_STOP;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      case (phase_q)
         PH_START:  line_o = 1'b0;
         PH_DATA:   line_o = shreg_q[0];
         PH_PARITY: line_o = par_q;
         default:   line_o = 1'b1;
      endcase
   end

   a_r2_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !bit_end_i && !launch_o) |=> $stable(line_o));

   a_r6_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_STOP && bit_end_i && valid_i && cts_ok_i) |=> (phase_q == PH_START && !line_o));

   a_r8_no_midframe_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && phase_q != PH_STOP) |-> !ready_o);

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
   import ser_tx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned OSR        = 16,
   parameter int unsigned CTS_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              tx_valid_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              tx_ready_o,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   input  logic              flow_en_i,
   input  logic              cts_ni,
   input  logic              ovr_en_i,
   input  logic              ovr_val_i,
   output logic              txd_o,
   output logic              busy_o
);

   logic cts_sync_n;
   logic cts_ok;
   logic par_bit;
   logic bit_end;
   logic launch;
   logic ser_line;
   fmt_t fmt;

   assign fmt.par_en  = par_en_i;
   assign fmt.par_odd = par_odd_i;

   ser_tx_cts_sync #(.STAGES(CTS_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (cts_ni),
      .sync_o  (cts_sync_n)
   );

   assign cts_ok = !flow_en_i || !cts_sync_n;

   ser_tx_parity #(.DATA_W(DATA_W)) u_par (
      .data_i (tx_data_i),
      .odd_i  (fmt.par_odd),
      .par_o  (par_bit)
   );

   ser_tx_bit_timer #(.OSR(OSR)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .run_i     (busy_o),
      .restart_i (launch),
      .bit_end_o (bit_end)
   );

   ser_tx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .bit_end_i (bit_end),
      .cts_ok_i  (cts_ok),
      .valid_i   (tx_valid_i),
      .data_i    (tx_data_i),
      .par_bit_i (par_bit),
      .fmt_i     (fmt),
      .ready_o   (tx_ready_o),
      .launch_o  (launch),
      .busy_o    (busy_o),
      .line_o    (ser_line)
   );

   // Override sits after the serializer, which keeps its own timing underneath.
   assign txd_o = ovr_en_i ? ovr_val_i : ser_line;

   a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !ovr_en_i) |-> txd_o);

   a_r5_ready_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_ready_o |-> tick_i);

   a_r7_cts_respected: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_ready_o |-> !(flow_en_i && cts_sync_n));

   a_r2_starts_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_valid_i && tx_ready_o) |=> (busy_o && (ovr_en_i || !txd_o)));

endmodule

// File: tb/sim_serial_tx_engine.sv
module sim_serial_tx_engine;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       valid = 1'b0;
   logic [7:0] data = 8'h00;
   logic       ready;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       flow_en = 1'b0;
   logic       cts_n = 1'b1;
   logic       ovr_en = 1'b0;
   logic       ovr_val = 1'b0;
   logic       txd;
   logic       busy;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int per = 1;
   int hs_cnt = 0;
   int b2b_cnt = 0;
   int bad_ready = 0;
   string mon_tag = "R2";

   always #4 clk = ~clk;

   serial_tx_engine u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .tick_i     (tick),
      .tx_valid_i (valid),
      .tx_data_i  (data),
      .tx_ready_o (ready),
      .par_en_i   (par_en),
      .par_odd_i  (par_odd),
      .flow_en_i  (flow_en),
      .cts_ni     (cts_n),
      .ovr_en_i   (ovr_en),
      .ovr_val_i  (ovr_val),
      .txd_o      (txd),
      .busy_o     (busy)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // Tick generator: one tick every 'per' cycles.
   initial begin
      int tc;
      tc = 0;
      forever begin
         @(posedge clk);
         tc = (tc + 1) % per;
         tick <= (tc == 0);
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit exp_bit(input logic [7:0] d, input bit pe, input bit po, input int b);
      if (b == 0) return 1'b0;
      if (b <= 8) return d[b-1];
      if (b == 9 && pe) return (^d) ^ po;
      return 1'b1;
   endfunction

   // Frame monitor: decodes every accepted byte at mid-bit positions.
   initial begin
      int prev_end;
      bit have_prev;
      have_prev = 0;
      prev_end = 0;
      forever begin
         @(negedge clk);
         if (rst_n && ready && !tick) bad_ready++;
         if (rst_n && valid && ready) begin
            int e0, nb, p;
            logic [7:0] d;
            bit pe, po;
            logic [10:0] got, exp;
            e0 = cyc + 1; d = data; pe = par_en; po = par_odd; p = per;
            nb = pe ? 11 : 10;
            hs_cnt++;
            if (have_prev && e0 == prev_end) b2b_cnt++;
            prev_end = e0 + nb * 16 * p;
            have_prev = 1;
            got = '1; exp = '1;
            for (int b = 0; b < nb; b++) begin
               while (cyc < e0 + 16 * p * b + 8 * p) @(negedge clk);
               exp[b] = ovr_en ? ovr_val : exp_bit(d, pe, po, b);
               got[b] = txd;
            end
            check(got == exp, mon_tag, "frame bits", int'(got), int'(exp));
         end
      end
   end

   task automatic send(input logic [7:0] b);
      @(posedge clk); #1;
      valid = 1'b1;
      data  = b;
      do @(negedge clk); while (!ready);
      @(posedge clk); #1;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy);
   endtask

   task automatic idle_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(txd == 1'b1 && busy == 1'b0, "R1", "reset state", {txd, busy}, 2'b10);
      idle_wait(40);
      check(txd == 1'b1, "R1", "idle line", txd, 1);

      // R2 R4 R6: all bytes, no parity, back-to-back
      mon_tag = "R2/R4/R6";
      begin
         int b0;
         b0 = b2b_cnt;
         for (int i = 0; i < 256; i++) send(8'(i));
         valid = 1'b0;
         wait_idle();
         check(b2b_cnt - b0 == 255, "R6", "back-to-back count", b2b_cnt - b0, 255);
      end
      idle_wait(20);
      check(txd == 1'b1, "R1", "idle after burst", txd, 1);

      // R3: even parity, all bytes
      mon_tag = "R3";
      par_en = 1'b1; par_odd = 1'b0;
      for (int i = 0; i < 256; i++) send(8'(i));
      valid = 1'b0;
      wait_idle();

      // R3: odd parity, spread of bytes
      par_odd = 1'b1;
      for (int i = 0; i < 256; i += 4) send(8'(i ^ (i >> 3)));
      valid = 1'b0;
      wait_idle();

      // R11: stretched tick spacing
      mon_tag = "R11";
      idle_wait(4);
      per = 3;
      idle_wait(6);
      send(8'hA5); send(8'h3C); par_en = 1'b0; send(8'h81);
      valid = 1'b0;
      wait_idle();
      per = 1;
      idle_wait(6);

      // R12: format changed mid-frame is ignored for that frame
      mon_tag = "R12";
      par_en = 1'b1; par_odd = 1'b0;
      send(8'h6B);
      valid = 1'b0;
      idle_wait(30);
      par_en = 1'b0; par_odd = 1'b1;
      wait_idle();
      par_en = 1'b1; par_odd = 1'b0;
      mon_tag = "R12";
      send(8'h17);
      valid = 1'b0;
      idle_wait(20);
      par_en = 1'b1; par_odd = 1'b1;
      wait_idle();
      par_en = 1'b0; par_odd = 1'b0;

      // R10: override at idle and across part of a frame
      @(posedge clk); #1 ovr_en = 1'b1; ovr_val = 1'b0;
      @(negedge clk);
      check(txd == 1'b0, "R10", "override low at idle", txd, 0);
      @(posedge clk); #1 ovr_val = 1'b1;
      @(negedge clk);
      check(txd == 1'b1, "R10", "override high at idle", txd, 1);
      mon_tag = "R10";
      ovr_val = 1'b0;
      send(8'hFF);
      valid = 1'b0;
      idle_wait(50);
      @(posedge clk); #1 ovr_en = 1'b0;
      wait_idle();
      check(txd == 1'b1, "R10", "released override idle", txd, 1);

      // R7: flow control holds start off
      mon_tag = "R7";
      flow_en = 1'b1; cts_n = 1'b1;
      idle_wait(4);
      begin
         int h0, t0;
         h0 = hs_cnt;
         @(posedge clk); #1 valid = 1'b1; data = 8'h5A;
         idle_wait(200);
         check(hs_cnt == h0 && txd == 1'b1, "R7", "held by cts", hs_cnt - h0, 0);
         @(posedge clk); #1 cts_n = 1'b0;
         t0 = cyc;
         do @(negedge clk); while (!ready);
         check(cyc - t0 <= 4, "R7", "start latency after cts", cyc - t0, 4);
         @(posedge clk); #1 valid = 1'b1; data = 8'hC3;
         // R8: cts toggled while frame is in flight
         mon_tag = "R8";
         idle_wait(40);
         @(posedge clk); #1 cts_n = 1'b1;
         h0 = hs_cnt;
         idle_wait(300);
         check(hs_cnt == h0, "R8", "no start while cts high", hs_cnt - h0, 0);
         check(txd == 1'b1 && busy == 1'b0, "R8", "line idle after frame", {txd, busy}, 2'b10);
         @(posedge clk); #1 cts_n = 1'b0;
         do @(negedge clk); while (!ready);
         @(posedge clk); #1 valid = 1'b0;
         wait_idle();
      end

      // R9: flow control off ignores cts
      mon_tag = "R9";
      flow_en = 1'b0; cts_n = 1'b1;
      idle_wait(4);
      begin
         int h0;
         h0 = hs_cnt;
         send(8'h99);
         valid = 1'b0;
         wait_idle();
         check(hs_cnt == h0 + 1, "R9", "start with cts high", hs_cnt - h0, 1);
      end

      check(bad_ready == 0, "R5", "ready without tick", bad_ready, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule